// File: doc/BRIEF.md
# Security-tagged write-back data cache

This block is a small two-way set-associative data cache for a processor that runs in either a secure or a non-secure world. Every request carries a world attribute. Each line's tag stores the world that filled it, and a lookup only matches a line of the caller's own world. Lines from both worlds can therefore sit side by side, and a world switch needs no flush and no invalidate.

Writes are held in the cache and reach memory only when a line is evicted or explicitly cleaned. Software can force a consistent state with clean and invalidate commands. Each command names an address and a world.

The memory side moves whole lines over a valid/ready port. That port carries the world of the line being moved. Only one miss is handled at a time, and while it runs the request port reports not-ready.

Top module: `sec_tag_cache`

## Requirements
- R1: A lookup hits only when a valid line's address tag matches and its stored world bit equals `req_ns`. A request from the other world misses, fetches its own copy and never sees the other world's data.
- R2: A line allocated on a miss stores the world of the request that caused it. The fill transfer drives `mem_ns` equal to that request's `req_ns` and `mem_write` low.
- R3: One address may be held twice in one set, once per world. Both copies stay valid when the world alternates, and each hits with its own data without memory traffic.
- R4: A write hit changes only the cached line, marks it dirty and causes no memory transfer. Memory receives the data only on eviction or clean.
- R5: A dirty victim is written back before the refill, with its own address and its own stored world on `mem_addr` and `mem_ns`. A transfer's address, direction and world stay stable until `mem_ready`.
- R6: On a miss the victim is an invalid way if one exists. Otherwise it is the least recently used way of the set, with one LRU bit per set updated on every read or write access.
- R7: Clean (`req_cmd` = 2) writes back a matching dirty line and leaves it valid and clean. A second clean causes no transfer, and later reads still hit.
- R8: Invalidate (`req_cmd` = 3) drops a matching line without writing it back. The next read misses and returns the memory contents.
- R9: Clean and invalidate affect only the line whose tag and world bit both match the command. A command naming the other world leaves the line untouched.
- R10: `req_ready` is low whenever a memory transfer is in progress, so at most one miss is outstanding.
- R11: A hit or a maintenance command without a transfer answers with `rsp_valid` one cycle after acceptance. A miss answers one cycle after the fill handshake. `rsp_rdata` carries the read word, or the merged word for a write.
- R12: After reset all lines are invalid, `req_ready` is high, and `mem_valid` and `rsp_valid` are low.
- R13: A write changes only the bytes whose `req_be` bit is set. Bit i covers data bits 8i+7..8i of the word, and the word within the line is selected by `req_addr[3:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_cmd | input | 2 | 0 read, 1 write, 2 clean, 3 invalidate |
| req_addr | input | ADDR_W | Byte address |
| req_ns | input | 1 | Requester world: 1 non-secure, 0 secure |
| req_wdata | input | WORD_W | Write data |
| req_be | input | WORD_W/8 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read word or merged write word |
| mem_valid | output | 1 | Line transfer requested |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_write | output | 1 | 1 write-back, 0 fill |
| mem_addr | output | ADDR_W | Line-aligned address |
| mem_ns | output | 1 | World attribute of the transfer |
| mem_wdata | output | LINE_BYTES*8 | Write-back line |
| mem_rdata | input | LINE_BYTES*8 | Fill line, sampled with mem_ready |

## Verification
A wrong stored world bit or a tag mismatch shows up at the ports the same cycle it is used. It appears as a fill where a hit was due, or as a read that returns the other world's word one cycle after acceptance. A lost dirty bit shows only later, when the line is cleaned or evicted and memory holds stale data. For that reason the bench ends every sweep by cleaning every line and comparing memory word by word against its arithmetic shadow. A stale LRU bit shows at the next miss in that set, as a write-back of the wrong line's address or world.

// File: rtl/sec_tag_cache.sv
module sec_tag_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 8,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_cmd,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_ns,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [WORD_W/8-1:0]     req_be,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ns,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BE_W   = WORD_W / 8;
  localparam int WORDS  = LINE_BYTES / BE_W;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int LSB_W  = OFF_W - WSEL_W;

  localparam logic [1:0] CMD_RD  = 2'd0;
  localparam logic [1:0] CMD_WR  = 2'd1;
  localparam logic [1:0] CMD_CLN = 2'd2;
  localparam logic [1:0] CMD_INV = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} st_t;
  st_t state;

  logic [TAG_W-1:0]  tag_q [2][SETS];
  logic [LINE_W-1:0] dat_q [2][SETS];
  logic [SETS-1:0]   vld_q [2];
  logic [SETS-1:0]   dty_q [2];
  logic [SETS-1:0]   ns_q  [2];
  logic [SETS-1:0]   lru_q;

  logic [1:0]        c_cmd;
  logic [SET_W-1:0]  c_set;
  logic [TAG_W-1:0]  c_tag;
  logic [WSEL_W-1:0] c_sel;
  logic [WORD_W-1:0] c_wdata;
  logic [BE_W-1:0]   c_be;
  logic              c_ns;
  logic              c_way;

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel,
                                                 input logic [WORD_W-1:0] w,
                                                 input logic [BE_W-1:0]   be);
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[int'(sel)*WORD_W + b*8 +: 8] = w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel);
    return line[int'(sel)*WORD_W +: WORD_W];
  endfunction

  logic [SET_W-1:0]  in_set;
  logic [TAG_W-1:0]  in_tag;
  logic [WSEL_W-1:0] in_sel;
  logic [1:0]        hit;
  logic              hit_any, hit_way, victim;
  logic [LINE_W-1:0] hit_line, hit_merged, fill_line;
  logic              unused_lsb;

  assign in_set  = req_addr[OFF_W +: SET_W];
  assign in_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign in_sel  = req_addr[LSB_W +: WSEL_W];
  assign unused_lsb = ^req_addr[LSB_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit[w] = vld_q[w][in_set] && (tag_q[w][in_set] == in_tag)
                    && (ns_q[w][in_set] == req_ns);
  end

  assign hit_any    = |hit;
  assign hit_way    = hit[1];
  assign victim     = !vld_q[0][in_set] ? 1'b0 :
                      !vld_q[1][in_set] ? 1'b1 : lru_q[in_set];
  assign hit_line   = dat_q[hit_way][in_set];
  assign hit_merged = put_word(hit_line, in_sel, req_wdata, req_be);
  assign fill_line  = (c_cmd == CMD_WR) ? put_word(mem_rdata, c_sel, c_wdata, c_be) : mem_rdata;

  assign req_ready = (state == ST_IDLE);
  assign mem_valid = (state != ST_IDLE);
  assign mem_write = (state == ST_WB);
  assign mem_addr  = (state == ST_WB) ? {tag_q[c_way][c_set], c_set, {OFF_W{1'b0}}}
                                      : {c_tag, c_set, {OFF_W{1'b0}}};
  assign mem_ns    = (state == ST_WB) ? ns_q[c_way][c_set] : c_ns;
  assign mem_wdata = dat_q[c_way][c_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      lru_q     <= '0;
      c_cmd <= '0; c_set <= '0; c_tag <= '0; c_sel <= '0;
      c_wdata <= '0; c_be <= '0; c_ns <= 1'b0; c_way <= 1'b0;
      for (int w = 0; w < 2; w++) begin
        vld_q[w] <= '0;
        dty_q[w] <= '0;
        ns_q[w]  <= '0;
        for (int s = 0; s < SETS; s++) begin
          tag_q[w][s] <= '0;
          dat_q[w][s] <= '0;
        end
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          c_cmd   <= req_cmd;
          c_set   <= in_set;
          c_tag   <= in_tag;
          c_sel   <= in_sel;
          c_wdata <= req_wdata;
          c_be    <= req_be;
          c_ns    <= req_ns;
          c_way   <= hit_any ? hit_way : victim;
          case (req_cmd)
            CMD_RD, CMD_WR: begin
              if (hit_any) begin
                rsp_valid       <= 1'b1;
                lru_q[in_set]   <= ~hit_way;
                if (req_cmd == CMD_WR) begin
                  dat_q[hit_way][in_set] <= hit_merged;
                  dty_q[hit_way][in_set] <= 1'b1;
                  rsp_rdata              <= get_word(hit_merged, in_sel);
                end else begin
                  rsp_rdata <= get_word(hit_line, in_sel);
                end
              end else if (vld_q[victim][in_set] && dty_q[victim][in_set]) begin
                state <= ST_WB;
              end else begin
                state <= ST_FILL;
              end
            end
            CMD_CLN: begin
              if (hit_any && dty_q[hit_way][in_set]) begin
                state <= ST_WB;
              end else begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
              end
            end
            CMD_INV: begin
              if (hit_any) begin
                vld_q[hit_way][in_set] <= 1'b0;
                dty_q[hit_way][in_set] <= 1'b0;
              end
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
            default: ;
          endcase
        end
        ST_WB: if (mem_ready) begin
          dty_q[c_way][c_set] <= 1'b0;
          if (c_cmd == CMD_CLN) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
            state     <= ST_IDLE;
          end else begin
            state <= ST_FILL;
          end
        end
        ST_FILL: if (mem_ready) begin
          dat_q[c_way][c_set] <= fill_line;
          tag_q[c_way][c_set] <= c_tag;
          vld_q[c_way][c_set] <= 1'b1;
          dty_q[c_way][c_set] <= (c_cmd == CMD_WR);
          ns_q[c_way][c_set]  <= c_ns;
          lru_q[c_set]        <= ~c_way;
          rsp_valid           <= 1'b1;
          rsp_rdata           <= get_word(fill_line, c_sel);
          state               <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sec_tag_cache_chk.sv
module sec_tag_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ns
);
  // R12
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (req_ready && !mem_valid && !rsp_valid)
        else $error("reset state not idle");
    end
  end

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R11
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write) |=> rsp_valid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && !mem_valid));

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_ns) && $stable(mem_write)));

  // R7
  wb_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_write) |=> ((mem_valid && !mem_write) || rsp_valid));
endmodule

bind sec_tag_cache sec_tag_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_ns(mem_ns)
);

// File: tb/sec_tag_cache_tb.sv
`timescale 1ns/1ps
module sec_tag_cache_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_cmd = 2'd0;
  logic [31:0]  req_addr = '0;
  logic         req_ns = 1'b0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_be = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic         mem_write;
  logic [31:0]  mem_addr;
  logic         mem_ns;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;

  always #5 clk = ~clk;

  sec_tag_cache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_ns(req_ns), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_ns(mem_ns), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int failures = 0;
  int fill_cnt = 0;
  int wb_cnt = 0;
  int resp_lat = 0;
  logic        last_fill_ns, last_wb_ns;
  logic [31:0] last_fill_addr, last_wb_addr;
  logic [127:0] mem_m [0:255];
  logic [31:0]  shadow [0:1][0:127];

  function automatic logic [31:0] init_word(input logic ns, input logic [31:0] a);
    return {ns ? 16'hC3C3 : 16'h3C3C, a[15:0]};
  endfunction

  function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [31:0] w,
                                         input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mem_word(input logic ns, input logic [31:0] a);
    logic [127:0] l;
    l = mem_m[{ns, a[10:4]}];
    return l[a[3:2]*32 +: 32];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: two-cycle latency, acts on falling edges
  int mlat = 0;
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      mlat++;
      if (mlat == 2) begin
        mlat = 0;
        chk("R10 ready low during transfer", {31'd0, req_ready}, 32'd0);
        mem_ready = 1'b1;
        if (mem_write) begin
          mem_m[{mem_ns, mem_addr[10:4]}] = mem_wdata;
          wb_cnt++;
          last_wb_ns = mem_ns;
          last_wb_addr = mem_addr;
        end else begin
          mem_rdata = mem_m[{mem_ns, mem_addr[10:4]}];
          fill_cnt++;
          last_fill_ns = mem_ns;
          last_fill_addr = mem_addr;
        end
      end
    end
  end

  task automatic do_req(input logic [1:0] cmd, input logic [31:0] addr, input logic ns,
                        input logic [31:0] wd, input logic [3:0] be,
                        output logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = cmd; req_addr = addr; req_ns = ns; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    resp_lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      resp_lat++;
    end
    rd = rsp_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_ns1;
    int f0, w0;
    for (int n = 0; n < 2; n++)
      for (int l = 0; l < 128; l++) begin
        logic [127:0] v;
        for (int k = 0; k < 4; k++) v[k*32 +: 32] = init_word(n[0], l*16 + k*4);
        mem_m[{n[0], l[6:0]}] = v;
      end

    repeat (3) @(negedge clk);
    chk("R12 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R12 mem_valid in reset", {31'd0, mem_valid}, 32'd0);
    chk("R12 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill secure copy of A
    do_req(2'd0, 32'h100, 1'b0, 0, 0, rd);
    chk("R2 secure fill count", fill_cnt, 1);
    chk("R2 fill world", {31'd0, last_fill_ns}, 32'd0);
    chk("R11 miss read data", rd, init_word(0, 32'h100));
    // non-secure access to same address must not hit secure line
    do_req(2'd0, 32'h100, 1'b1, 0, 0, rd);
    chk("R1 other world misses", fill_cnt, 2);
    chk("R2 fill world ns", {31'd0, last_fill_ns}, 32'd1);
    chk("R1 other world data", rd, init_word(1, 32'h100));
    // both copies coexist, alternate worlds without flush
    f0 = fill_cnt;
    do_req(2'd0, 32'h100, 1'b0, 0, 0, rd);
    chk("R3 secure copy data", rd, init_word(0, 32'h100));
    chk("R11 hit latency", resp_lat, 1);
    do_req(2'd0, 32'h100, 1'b1, 0, 0, rd);
    chk("R3 ns copy data", rd, init_word(1, 32'h100));
    chk("R6 invalid way used, both hit", fill_cnt, f0);
    // partial write on ns copy
    w0 = wb_cnt;
    exp_ns1 = bmerge(init_word(1, 32'h100), 32'hDEADBEEF, 4'b0101);
    do_req(2'd1, 32'h100, 1'b1, 32'hDEADBEEF, 4'b0101, rd);
    chk("R13 write response merged", rd, exp_ns1);
    chk("R4 write hit no traffic", fill_cnt + wb_cnt, f0 + w0);
    do_req(2'd0, 32'h100, 1'b1, 0, 0, rd);
    chk("R13 byte enables", rd, exp_ns1);
    chk("R4 memory not yet updated", mem_word(1, 32'h100), init_word(1, 32'h100));
    do_req(2'd0, 32'h100, 1'b0, 0, 0, rd);
    chk("R1 secure copy untouched", rd, init_word(0, 32'h100));
    // conflict miss in set 0: LRU way is the dirty ns copy
    do_req(2'd0, 32'h180, 1'b0, 0, 0, rd);
    chk("R5 victim written back", wb_cnt, w0 + 1);
    chk("R5 victim world", {31'd0, last_wb_ns}, 32'd1);
    chk("R6 LRU victim address", last_wb_addr, 32'h100);
    chk("R5 written data", mem_word(1, 32'h100), exp_ns1);
    chk("R2 refill world", {31'd0, last_fill_ns}, 32'd0);
    chk("R2 refill addr", last_fill_addr, 32'h180);
    chk("R11 refill data", rd, init_word(0, 32'h180));
    // clean
    do_req(2'd1, 32'h100, 1'b0, 32'h11223344, 4'hF, rd);
    w0 = wb_cnt;
    do_req(2'd2, 32'h100, 1'b1, 0, 0, rd);
    chk("R9 clean other world no traffic", wb_cnt, w0);
    do_req(2'd2, 32'h100, 1'b0, 0, 0, rd);
    chk("R7 clean writes back", wb_cnt, w0 + 1);
    chk("R7 clean world", {31'd0, last_wb_ns}, 32'd0);
    chk("R7 clean data", mem_word(0, 32'h100), 32'h11223344);
    do_req(2'd2, 32'h100, 1'b0, 0, 0, rd);
    chk("R7 second clean idle", wb_cnt, w0 + 1);
    f0 = fill_cnt;
    do_req(2'd0, 32'h100, 1'b0, 0, 0, rd);
    chk("R7 line stays valid", fill_cnt, f0);
    chk("R7 read after clean", rd, 32'h11223344);
    // invalidate
    do_req(2'd1, 32'h100, 1'b0, 32'h55667788, 4'hF, rd);
    do_req(2'd3, 32'h100, 1'b1, 0, 0, rd);
    do_req(2'd0, 32'h100, 1'b0, 0, 0, rd);
    chk("R9 invalidate other world no effect", rd, 32'h55667788);
    chk("R9 still hit", fill_cnt, f0);
    w0 = wb_cnt;
    do_req(2'd3, 32'h100, 1'b0, 0, 0, rd);
    chk("R8 invalidate no writeback", wb_cnt, w0);
    do_req(2'd0, 32'h100, 1'b0, 0, 0, rd);
    chk("R8 refetch after invalidate", fill_cnt, f0 + 1);
    chk("R8 dirty data dropped", rd, 32'h11223344);

    // sweep over lines 32..63 in both worlds against an arithmetic shadow
    for (int n = 0; n < 2; n++)
      for (int i = 0; i < 128; i++) shadow[n][i] = init_word(n[0], 32'h200 + i*4);
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int op = 0; op < 600; op++) begin
        logic        ns;
        logic [6:0]  wi;
        logic [31:0] a, wd;
        logic [3:0]  be;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ns = lf[0];
        wi = lf[7:1];
        a  = 32'h200 + {25'd0, wi} * 4;
        wd = {lf, ~lf};
        be = lf[11:8];
        if (lf[12] && lf[13]) begin
          do_req(2'd2, a, ns, 0, 0, rd);
        end else if (lf[14]) begin
          shadow[ns][wi] = bmerge(shadow[ns][wi], wd, be);
          do_req(2'd1, a, ns, wd, be, rd);
          chk("R13 sweep write response", rd, shadow[ns][wi]);
        end else begin
          do_req(2'd0, a, ns, 0, 0, rd);
          chk("R1 sweep read world data", rd, shadow[ns][wi]);
        end
      end
    end
    for (int n = 0; n < 2; n++)
      for (int l = 0; l < 32; l++) do_req(2'd2, 32'h200 + l*16, n[0], 0, 0, rd);
    for (int n = 0; n < 2; n++)
      for (int i = 0; i < 128; i++)
        chk("R4 memory after clean", mem_word(n[0], 32'h200 + i*4), shadow[n][i]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule